// File: doc/BRIEF.md
# Two-Plane NAND Page Program Sequencer

This controller runs a two-plane page program on an 8-bit asynchronous NAND flash bus. One request carries two block numbers, one page number per plane, a starting column and a byte count per plane. The sequencer first checks the request. It then writes the first plane's setup command, its five address bytes and its data, and closes that plane with the intermediate command. It waits out the short busy period on the ready/busy line, repeats the setup for the second plane, and closes with the confirm command. After the long program busy it reads the status byte and reports the result.

Data arrives on a valid/ready byte stream that is tagged with a plane index. The stream is stalled whenever the bus is not in a data phase for the plane the byte is tagged with. All bus timing values are clock-cycle counts supplied on configuration inputs. Each ready/busy wait is bounded by a timeout.

Top module: `nand_mp_prog`

## Requirements
- R1: Out of reset and while idle, chip enable, write enable and read enable are all high (inactive), `req_ready` is 1, `done` is 0 and `din_ready` is 0.
- R2: A request whose two page numbers differ ends with `done` and `res` = 2 (rejected) within two cycles. Chip enable never goes low and no bus cycle is issued.
- R3: The first plane phase writes, in this order: command 80h, column bits 7:0, column bits 14:8, row byte 0, row byte 1, row byte 2, the plane-0 data bytes in stream order, then command 11h.
- R4: The 24-bit row address is {zeros, block[10:0], plane bit, page[7:0]}. The plane bit (row bit 8, bit 0 of row byte 1) is 0 in the first phase and 1 in the second. Each phase carries its own block number and the same page.
- R5: After 11h the sequencer waits at least `cfg_twb` cycles and until the synchronised ready/busy line shows ready before it writes 81h. Between 11h and 81h it writes no command other than 70h, 78h, 75h or FFh.
- R6: The second plane phase writes 81h, the five address bytes, the plane-1 data bytes, then 10h.
- R7: At least `cfg_tadl` cycles separate the write-enable rising edge of the last address byte from the write-enable rising edge of the first data byte, in both phases.
- R8: Every write-enable low pulse lasts at least `cfg_twc` cycles. Consecutive write-enable rising edges are at least 2·`cfg_twc` cycles apart.
- R9: After program busy ends, the sequencer writes 70h, waits at least `cfg_twhr` cycles, and pulses read enable once. `res` is 1 (fail) if I/O bit 0 was 1 and 0 (pass) if it was 0.
- R10: If the ready/busy line stays busy for more than `cfg_tmo` cycles, the operation ends with `res` = 3 (timeout) and no status read.
- R11: `din_ready` is high only during a data phase, and only for the plane the byte is tagged with. Bytes of the other plane are held off until their phase.
- R12: A command is written with CLE high and ALE low, an address byte with ALE high and CLE low, and a data byte with both low. CLE and ALE are never both high during a write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_twc | input | TW | Write/read pulse half-period in cycles (at least 1) |
| cfg_twb | input | TW | Wait after a busy-causing command (at least 3) |
| cfg_tadl | input | TW | Minimum gap from last address to first data |
| cfg_twhr | input | TW | Minimum gap from status command to read |
| cfg_tmo | input | MW | Ready/busy wait timeout in cycles |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle and accepting a request |
| req_blk0 | input | BW | Block number, plane 0 |
| req_blk1 | input | BW | Block number, plane 1 |
| req_page0 | input | PW | Page for plane 0 |
| req_page1 | input | PW | Page for plane 1 (must equal req_page0) |
| req_col | input | CW | Starting column |
| req_len | input | LW | Data bytes per plane |
| din_valid | input | 1 | Data byte valid |
| din_ready | output | 1 | Data byte taken |
| din_data | input | 8 | Data byte |
| din_plane | input | 1 | Plane the byte belongs to |
| done | output | 1 | One-cycle completion pulse |
| res | output | 2 | 0 pass, 1 fail, 2 rejected, 3 timeout |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_io_out | output | 8 | I/O bus drive value |
| nand_io_oe | output | 1 | I/O bus drive enable |
| nand_io0_in | input | 1 | I/O bit 0 read back from the device |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
The bench models the flash device, logs every latched bus cycle with a cycle stamp, and compares the log against a sequence built from the request. This catches a swapped plane bit, the page of the wrong plane, or data bytes taken from the wrong plane stream, any of which shows up as a mismatched log entry. The stamps expose a sequencer that writes 81h before the short busy has ended, or that starts data too early after the address. Single-byte, long-transfer, top-column and top-block requests exercise the length and address boundaries. Directed cases cover a failing status bit, a device that never returns ready, and mismatched pages. A broken design would report pass, hang, or touch the bus in these cases.

// File: rtl/nand_mp_prog.sv
module nand_mp_prog #(
  parameter int TW = 8,
  parameter int MW = 16,
  parameter int BW = 11,
  parameter int PW = 8,
  parameter int CW = 15,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cfg_twc,
  input  logic [TW-1:0] cfg_twb,
  input  logic [TW-1:0] cfg_tadl,
  input  logic [TW-1:0] cfg_twhr,
  input  logic [MW-1:0] cfg_tmo,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [BW-1:0] req_blk0,
  input  logic [BW-1:0] req_blk1,
  input  logic [PW-1:0] req_page0,
  input  logic [PW-1:0] req_page1,
  input  logic [CW-1:0] req_col,
  input  logic [LW-1:0] req_len,
  input  logic          din_valid,
  output logic          din_ready,
  input  logic [7:0]    din_data,
  input  logic          din_plane,
  output logic          done,
  output logic [1:0]    res,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [7:0]    nand_io_out,
  output logic          nand_io_oe,
  input  logic          nand_io0_in,
  input  logic          nand_rb_n
);
  localparam int RW = BW + 1 + PW;
  localparam logic [TW:0] ONE = 1;
  localparam logic [MW-1:0] MONE = 1;
  localparam logic [LW-1:0] LONE = 1;
  localparam logic [1:0] R_PASS = 2'd0, R_FAIL = 2'd1, R_REJ = 2'd2, R_TMO = 2'd3;

  typedef enum logic [3:0] {S_IDLE, S_CMD, S_ADDR, S_ADL, S_DATA, S_WB, S_BUSY, S_WHR, S_READ, S_DONE} st_t;
  st_t st;

  logic [TW:0]   cnt;
  logic [MW-1:0] tmo;
  logic [2:0]    idx;
  logic          plane, have;
  logic [LW-1:0] nleft, len_q;
  logic [CW-1:0] col_q;
  logic [PW-1:0] page_q;
  logic [BW-1:0] blk0_q, blk1_q;
  logic [7:0]    cmd_q, dq, ab;
  logic [1:0]    res_q, rb_s;

  logic [TW:0] twc_x, twc2m1;
  assign twc_x  = {1'b0, cfg_twc};
  assign twc2m1 = {cfg_twc, 1'b0} - ONE;

  wire wr_st   = (st == S_CMD) || (st == S_ADDR) || (st == S_DATA && have);
  wire cyc_end = (cnt == twc2m1);
  wire lo_half = (cnt < twc_x);

  logic [RW-1:0] row;
  logic [23:0]   row24;
  logic [15:0]   col16;
  assign row   = {plane ? blk1_q : blk0_q, plane, page_q};
  assign row24 = 24'(row);
  assign col16 = 16'(col_q);

  always_comb begin
    case (idx)
      3'd0:    ab = col16[7:0];
      3'd1:    ab = col16[15:8];
      3'd2:    ab = row24[7:0];
      3'd3:    ab = row24[15:8];
      default: ab = row24[23:16];
    endcase
  end

  assign nand_ce_n   = (st == S_IDLE) || (st == S_DONE);
  assign nand_cle    = (st == S_CMD);
  assign nand_ale    = (st == S_ADDR);
  assign nand_we_n   = !(wr_st && lo_half);
  assign nand_re_n   = !(st == S_READ && lo_half);
  assign nand_io_out = (st == S_CMD) ? cmd_q : (st == S_ADDR) ? ab : dq;
  assign nand_io_oe  = wr_st;
  assign req_ready   = (st == S_IDLE);
  assign din_ready   = (st == S_DATA) && !have && (din_plane == plane);
  assign done        = (st == S_DONE);
  assign res         = res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; tmo <= '0; idx <= '0; plane <= 1'b0; have <= 1'b0;
      nleft <= '0; len_q <= '0; col_q <= '0; page_q <= '0; blk0_q <= '0; blk1_q <= '0;
      cmd_q <= 8'h00; dq <= 8'h00; res_q <= R_PASS; rb_s <= 2'b11;
    end else begin
      rb_s <= {rb_s[0], nand_rb_n};
      case (st)
        S_IDLE: if (req_valid) begin
          blk0_q <= req_blk0; blk1_q <= req_blk1; page_q <= req_page0;
          col_q <= req_col; len_q <= req_len; plane <= 1'b0; cnt <= '0;
          if (req_page0 != req_page1) begin res_q <= R_REJ; st <= S_DONE; end
          else begin cmd_q <= 8'h80; st <= S_CMD; end
        end
        S_CMD: if (cyc_end) begin
          cnt <= '0; idx <= '0;
          case (cmd_q)
            8'h80, 8'h81: st <= S_ADDR;
            8'h11, 8'h10: st <= S_WB;
            default:      st <= S_WHR;
          endcase
        end else cnt <= cnt + ONE;
        S_ADDR: if (cyc_end) begin
          cnt <= '0;
          if (idx == 3'd4) st <= S_ADL; else idx <= idx + 3'd1;
        end else cnt <= cnt + ONE;
        S_ADL: if (cnt >= {1'b0, cfg_tadl}) begin
          cnt <= '0; nleft <= len_q; have <= 1'b0;
          if (len_q == '0) begin cmd_q <= plane ? 8'h10 : 8'h11; st <= S_CMD; end
          else st <= S_DATA;
        end else cnt <= cnt + ONE;
        S_DATA: if (!have) begin
          if (din_valid && din_ready) begin dq <= din_data; have <= 1'b1; cnt <= '0; end
        end else if (cyc_end) begin
          have <= 1'b0; cnt <= '0; nleft <= nleft - LONE;
          if (nleft == LONE) begin cmd_q <= plane ? 8'h10 : 8'h11; st <= S_CMD; end
        end else cnt <= cnt + ONE;
        S_WB: if (cnt >= {1'b0, cfg_twb}) begin
          cnt <= '0; tmo <= '0; st <= S_BUSY;
        end else cnt <= cnt + ONE;
        S_BUSY: if (rb_s[1]) begin
          cnt <= '0; st <= S_CMD;
          if (!plane) begin plane <= 1'b1; cmd_q <= 8'h81; end
          else cmd_q <= 8'h70;
        end else if (tmo == cfg_tmo) begin
          res_q <= R_TMO; st <= S_DONE;
        end else tmo <= tmo + MONE;
        S_WHR: if (cnt >= {1'b0, cfg_twhr}) begin
          cnt <= '0; st <= S_READ;
        end else cnt <= cnt + ONE;
        S_READ: begin
          if (lo_half) res_q <= nand_io0_in ? R_FAIL : R_PASS;
          if (cyc_end) st <= S_DONE; else cnt <= cnt + ONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic in_win;
  logic [TW:0] lo_cnt, ad_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_win <= 1'b0; lo_cnt <= '0; ad_cnt <= '0;
    end else begin
      if (st == S_CMD && cyc_end && cmd_q == 8'h11) in_win <= 1'b1;
      else if (st == S_CMD && cmd_q == 8'h81) in_win <= 1'b0;
      if (nand_we_n) lo_cnt <= '0;
      else if (lo_cnt != '1) lo_cnt <= lo_cnt + ONE;
      if (st == S_ADDR && idx == 3'd4 && cnt == twc_x) ad_cnt <= '0;
      else if (ad_cnt != '1) ad_cnt <= ad_cnt + ONE;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) nand_ce_n |-> (nand_we_n && nand_re_n)); // R1
  AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready && req_page0 != req_page1) |=> (done && res == 2'd2 && nand_ce_n)); // R2
  AST_WIN_CMDS: assert property (@(posedge clk) disable iff (!rst_n) (in_win && nand_cle) |-> (nand_io_out inside {8'h70, 8'h78, 8'h75, 8'hFF, 8'h81})); // R5
  AST_ADL_GAP: assert property (@(posedge clk) disable iff (!rst_n) (st == S_DATA && have && cnt == twc_x && nleft == len_q) |-> (ad_cnt >= {1'b0, cfg_tadl})); // R7
  AST_WE_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(nand_we_n) |-> (lo_cnt >= twc_x)); // R8
  AST_READY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n) din_ready |-> (!nand_cle && !nand_ale && !nand_ce_n)); // R11
  AST_LATCH_MODE: assert property (@(posedge clk) disable iff (!rst_n) !nand_we_n |-> !(nand_cle && nand_ale)); // R12
endmodule

// File: tb/tb_nand_mp_prog.sv
module tb_nand_mp_prog;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] cfg_twc = 8'd1, cfg_twb = 8'd4, cfg_tadl = 8'd0, cfg_twhr = 8'd0;
  logic [15:0] cfg_tmo = 16'd1000;
  logic req_valid = 1'b0, req_ready;
  logic [10:0] req_blk0 = '0, req_blk1 = '0;
  logic [7:0] req_page0 = '0, req_page1 = '0;
  logic [14:0] req_col = '0;
  logic [4:0] req_len = '0;
  logic din_valid = 1'b0, din_ready, din_plane = 1'b0;
  logic [7:0] din_data = '0;
  logic done;
  logic [1:0] res;
  logic ce_n, cle, ale, we_n, re_n, io_oe, io0, rb_n = 1'b1;
  logic [7:0] io_out;
  bit fail_bit = 0;

  assign io0 = re_n ? 1'b0 : fail_bit;

  nand_mp_prog dut (
    .clk(clk), .rst_n(rst_n), .cfg_twc(cfg_twc), .cfg_twb(cfg_twb), .cfg_tadl(cfg_tadl),
    .cfg_twhr(cfg_twhr), .cfg_tmo(cfg_tmo), .req_valid(req_valid), .req_ready(req_ready),
    .req_blk0(req_blk0), .req_blk1(req_blk1), .req_page0(req_page0), .req_page1(req_page1),
    .req_col(req_col), .req_len(req_len), .din_valid(din_valid), .din_ready(din_ready),
    .din_data(din_data), .din_plane(din_plane), .done(done), .res(res),
    .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
    .nand_io_out(io_out), .nand_io_oe(io_oe), .nand_io0_in(io0), .nand_rb_n(rb_n));

  int checks = 0, errors = 0;
  int cyc = 0;
  int ent_n = 0;
  int ent_k [0:127];
  logic [7:0] ent_io [0:127];
  int ent_t [0:127];
  int lo_run = 0, last_rise = -1000, busy_cnt = 0, busy_end1 = -1, re_cnt = 0, re_fall = -1;
  int dbsy = 5, prog = 30;
  bit hang = 0, wc_bad = 0, rdy_bad = 0, ce_seen = 0, take = 0;
  logic we_prev = 1'b1, re_prev = 1'b1;
  logic [7:0] stream [0:31];
  int sptr = 0, stot = 0, slen = 0;

  task automatic chk(input string rq, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!ce_n) ce_seen = 1;
    if (!we_n) lo_run++;
    if (!we_prev && we_n) begin
      int k;
      if (lo_run < int'(cfg_twc)) wc_bad = 1;
      if (cyc - last_rise < 2 * int'(cfg_twc)) wc_bad = 1;
      last_rise = cyc; lo_run = 0;
      k = (cle && !ale) ? 0 : (ale && !cle) ? 1 : (!cle && !ale) ? 2 : 3;
      if (ent_n < 128) begin
        ent_k[ent_n] = k; ent_io[ent_n] = io_out; ent_t[ent_n] = cyc; ent_n++;
      end
      if (k == 0 && io_out == 8'h11) busy_cnt = dbsy;
      if (k == 0 && io_out == 8'h10) busy_cnt = hang ? 1000000 : prog;
    end else if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0 && busy_end1 < 0) busy_end1 = cyc;
    end
    rb_n = (busy_cnt == 0);
    if (re_prev && !re_n) begin re_cnt++; re_fall = cyc; end
    we_prev = we_n; re_prev = re_n;
    if (take) sptr++;
    if (sptr < stot && ($urandom % 4) != 0) begin
      din_valid = 1'b1; din_data = stream[sptr]; din_plane = (sptr >= slen);
    end else din_valid = 1'b0;
    #1;
    take = din_valid && din_ready;
    if (din_ready && (cle || ale || ce_n)) rdy_bad = 1;
  end

  function automatic logic [7:0] abyte(input int i, input logic [14:0] col, input logic [7:0] pg,
                                       input logic pl, input logic [10:0] blk);
    logic [39:0] v;
    v = {4'b0, blk, pl, pg, 1'b0, col};
    return v[i*8 +: 8];
  endfunction

  task automatic run_txn(input logic [10:0] b0, input logic [10:0] b1, input logic [7:0] pg,
                         input logic [7:0] pg1, input logic [14:0] col, input int len,
                         input bit fb, input bit hg);
    int exp_k [0:127];
    logic [7:0] exp_io [0:127];
    int n, w, ok3, ok4, ok6, ok12, i11, i81, i70;
    for (int i = 0; i < 2 * len; i++) stream[i] = 8'($urandom);
    fail_bit = fb; hang = hg; busy_cnt = 0; busy_end1 = -1;
    ent_n = 0; re_cnt = 0; re_fall = -1; wc_bad = 0; rdy_bad = 0; ce_seen = 0;
    last_rise = -1000; lo_run = 0;
    @(negedge clk);
    sptr = 0; slen = len; stot = (pg == pg1) ? 2 * len : 0; take = 0;
    req_blk0 = b0; req_blk1 = b1; req_page0 = pg; req_page1 = pg1;
    req_col = col; req_len = 5'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    chk("R1 done seen", done, w, 0);
    if (pg != pg1) begin
      chk("R2 reject code", res == 2'd2, res, 2);
      chk("R2 reject latency", w <= 1, w, 1);
      chk("R2 no bus cycle", ent_n == 0 && !ce_seen, ent_n, 0);
      @(negedge clk);
      chk("R1 back to idle", req_ready && ce_n && we_n && re_n, req_ready, 1);
      return;
    end
    if (hg) begin
      chk("R10 timeout code", res == 2'd3, res, 3);
      chk("R10 no status read", re_cnt == 0, re_cnt, 0);
      busy_cnt = 0;
      return;
    end
    n = 0;
    for (int p = 0; p < 2; p++) begin
      exp_k[n] = 0; exp_io[n] = p ? 8'h81 : 8'h80; n++;
      for (int a = 0; a < 5; a++) begin
        exp_k[n] = 1; exp_io[n] = abyte(a, col, pg, p[0], p ? b1 : b0); n++;
      end
      for (int d = 0; d < len; d++) begin exp_k[n] = 2; exp_io[n] = stream[p * len + d]; n++; end
      exp_k[n] = 0; exp_io[n] = p ? 8'h10 : 8'h11; n++;
    end
    exp_k[n] = 0; exp_io[n] = 8'h70; n++;
    chk("R3 bus cycle count", ent_n == n, ent_n, n);
    ok3 = 1; ok4 = 1; ok6 = 1; ok12 = 1;
    for (int i = 0; i < n && i < ent_n; i++) begin
      if (ent_k[i] != exp_k[i]) ok12 = 0;
      if (ent_io[i] != exp_io[i]) begin
        if (i == 4 || i == 5 || i == 11 + len || i == 12 + len) ok4 = 0;
        else if (i <= 6 + len) ok3 = 0;
        else ok6 = 0;
      end
    end
    chk("R3 first plane sequence", ok3 == 1, ok3, 1);
    chk("R4 row bytes and plane bit", ok4 == 1, ok4, 1);
    chk("R6 second plane sequence", ok6 == 1, ok6, 1);
    chk("R12 latch encoding", ok12 == 1, ok12, 1);
    if (ent_n == n) begin
      i11 = 6 + len; i81 = 7 + len; i70 = n - 1;
      chk("R5 81h after ready", ent_t[i81] > busy_end1 && busy_end1 > 0, ent_t[i81], busy_end1 + 1);
      chk("R5 tWB before 81h", ent_t[i81] - ent_t[i11] >= int'(cfg_twb), ent_t[i81] - ent_t[i11], cfg_twb);
      chk("R7 tADL plane 0", ent_t[6] - ent_t[5] >= int'(cfg_tadl), ent_t[6] - ent_t[5], cfg_tadl);
      chk("R7 tADL plane 1", ent_t[13 + len] - ent_t[12 + len] >= int'(cfg_tadl),
          ent_t[13 + len] - ent_t[12 + len], cfg_tadl);
      chk("R9 tWHR", re_fall - ent_t[i70] >= int'(cfg_twhr), re_fall - ent_t[i70], cfg_twhr);
    end
    chk("R8 write pulse widths", !wc_bad, wc_bad, 0);
    chk("R9 one status read", re_cnt == 1, re_cnt, 1);
    chk("R9 status result", res == {1'b0, fb}, res, fb);
    chk("R11 stream consumed", sptr == stot && !rdy_bad, sptr, stot);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s;
    s = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", ce_n && we_n && re_n && req_ready && !done && !din_ready, req_ready, 1);
    cfg_twc = 1; cfg_tadl = 0; cfg_twb = 4; cfg_twhr = 0;
    run_txn(11'd5, 11'd6, 8'h3C, 8'h3C, 15'd0, 1, 0, 0);
    cfg_twc = 3; cfg_tadl = 7; cfg_twhr = 5;
    run_txn(11'h7FF, 11'h400, 8'hFF, 8'hFF, 15'h7FFF, 16, 1, 0);
    run_txn(11'd1, 11'd2, 8'h10, 8'h11, 15'd4, 4, 0, 0);
    cfg_tmo = 200;
    run_txn(11'd9, 11'd10, 8'h01, 8'h01, 15'd8, 2, 0, 1);
    cfg_tmo = 1000;
    for (int t = 0; t < 12; t++) begin
      logic [7:0] pg;
      cfg_twc = 8'(1 + $urandom % 3); cfg_tadl = 8'($urandom % 8);
      cfg_twb = 8'(4 + $urandom % 3); cfg_twhr = 8'($urandom % 6);
      dbsy = 2 + $urandom % 8; prog = 10 + $urandom % 40;
      pg = 8'($urandom);
      run_txn(11'($urandom), 11'($urandom), pg, pg, 15'($urandom), 1 + $urandom % 12,
              bit'($urandom % 2), 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule